// File: doc/BRIEF.md
# Transmit Frame Builder with Minimum-Length Padding

This block turns a single transmit request into a complete Ethernet frame in a byte-wide transmit buffer and then hands the frame to a transmitter. A request carries a destination address, a station address, a 16-bit type and a payload length. The payload bytes then arrive on a valid/ready stream. The block writes the 14-byte header, then the payload, then zero bytes until the frame is at least 60 bytes long. CRC is left to the transmitter.

The block holds the transmitter stopped while the buffer is filled. It writes one descriptor status word that carries the ownership flag and the final length, then lets the transmitter run. It polls the ownership and packet-good flags that the transmitter reports back. It finishes with a result code: success, transmit error, timeout, or rejection of a request too large for the buffer. The result code stays on its output until the next accepted request.

Top module: `tx_frame_builder`

## Requirements
- R1: After a request is accepted, buffer addresses 0 to 13 are written in increasing order. Addresses 0-5 take the destination address, most significant byte (`dst_addr[47:40]`) first. Addresses 6-11 take the station address in the same order. Address 12 takes `eth_type[15:8]` and address 13 takes `eth_type[7:0]`.
- R2: Payload bytes are written to addresses 14 onward in arrival order. A byte is taken only in a cycle where both `pay_valid` and `pay_ready` are high. Gaps in `pay_valid` do not change the written contents.
- R3: When 14 plus the payload length is below 60, zero bytes fill the remaining addresses up to and including 59. A frame of 60 bytes or more gets no fill bytes.
- R4: After the last buffer write, `desc_wr` is high for exactly one cycle. During that cycle `desc_status` has bit 31 set and bits 30:12 clear. Bits 11:0 hold the final length: max(60, (payload length + 14) mod 4096).
- R5: `tx_run` goes low in the cycle after a request is accepted and stays low through every buffer write and the descriptor write. It is high in the cycle after `desc_wr`.
- R6: After the descriptor write, the first cycle that sees `tx_own` low ends the transfer. The result is OK (1) if `tx_ok` is high in that cycle and TXERR (2) if it is low. `done` pulses for one cycle as the result appears.
- R7: If `tx_own` is still high for TIMEOUT_CYC consecutive cycles after the descriptor write, the result is TIMEOUT (3). `done` is then high TIMEOUT_CYC+1 cycles after the `desc_wr` cycle.
- R8: A request with payload length + 14 greater than BUF_BYTES gives the result REJECT (4) and a `done` pulse in the next cycle. It causes no buffer write, no descriptor write and no `busy` period.
- R9: Reset leaves `busy`, `done` and `tx_run` low and `res_code` at NONE (0). The result code changes only when `done` pulses or when a request is accepted (back to NONE), so it holds between requests.
- R10: A `start` pulse while `busy` is high is ignored. The frame in progress keeps its latched header fields and length, and no REJECT result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| dst_addr | input | 48 | Destination address, first byte in [47:40] |
| src_addr | input | 48 | Station address, first byte in [47:40] |
| eth_type | input | 16 | Type field, sent high byte first |
| pay_len | input | LEN_W | Payload length in bytes |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Block takes a payload byte this cycle |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| desc_wr | output | 1 | Descriptor status write strobe |
| desc_status | output | 32 | Descriptor status word: owner flag and length |
| tx_own | input | 1 | Ownership flag read back from the descriptor (bit 31) |
| tx_ok | input | 1 | Packet-good flag read back from the descriptor (bit 27) |
| tx_run | output | 1 | Transmitter enable |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a result is set |
| res_code | output | 3 | 0 NONE, 1 OK, 2 TXERR, 3 TIMEOUT, 4 REJECT |

## Verification
The bench builds the block with BUF_BYTES=128 and TIMEOUT_CYC=40. The small buffer brings the rejection limit down to a payload of 114 bytes, so both the largest accepted frame (exactly 128 bytes) and the first rejected one can be tested. The short timeout makes the full timeout window and its exact `done` cycle cheap to measure. Payload lengths 0, 5, 45, 46, 114 and 115 cover heavy padding, one fill byte, no fill and the buffer limit.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

  localparam int HDR_BYTES = 14;
  localparam int MIN_FRAME = 60;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_OK      = 3'd1,
    RES_TXERR   = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_REJECT  = 3'd4
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_STOP, S_HDR, S_PAY, S_PAD, S_POST, S_WAIT
  } st_e;

  typedef enum logic [1:0] {
    K_HDR, K_PAY, K_PAD
  } kind_e;

  // Header byte by index: destination, station, type high, type low.
  function automatic logic [7:0] hdr_byte(input logic [3:0] idx,
                                          input logic [47:0] dst,
                                          input logic [47:0] src,
                                          input logic [15:0] typ);
    logic [111:0] hdr;
    hdr = {dst, src, typ};
    return hdr[111 - 8 * int'(idx) -: 8];
  endfunction

  function automatic logic [15:0] raw_len(input logic [15:0] plen);
    return plen + 16'(HDR_BYTES);
  endfunction

  // Length is cut to 12 bits first, then raised to the minimum frame size.
  function automatic logic [11:0] final_len(input logic [15:0] raw);
    logic [11:0] m;
    m = raw[11:0];
    return (m < 12'(MIN_FRAME)) ? 12'(MIN_FRAME) : m;
  endfunction

  function automatic logic [31:0] status_word(input logic [11:0] flen);
    return {1'b1, 19'd0, flen};
  endfunction

endpackage

// File: rtl/tfb_lencalc.sv
module tfb_lencalc
  import tfb_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic [15:0] plen,
  output logic [11:0] end_len,
  output logic [11:0] frame_len,
  output logic        too_big
);
  localparam logic [15:0] LIMIT = 16'(BUF_BYTES);

  logic [15:0] raw;

  always_comb begin
    raw       = raw_len(plen);
    end_len   = raw[11:0];
    frame_len = final_len(raw);
    too_big   = raw > LIMIT;
  end
endmodule

// File: rtl/tfb_bytesel.sv
module tfb_bytesel
  import tfb_pkg::*;
(
  input  kind_e       kind,
  input  logic [3:0]  hdr_idx,
  input  logic [47:0] dst,
  input  logic [47:0] src,
  input  logic [15:0] typ,
  input  logic [7:0]  pay,
  output logic [7:0]  wdata
);
  always_comb begin
    unique case (kind)
      K_HDR:   wdata = hdr_byte(hdr_idx, dst, src, typ);
      K_PAY:   wdata = pay;
      default: wdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tfb_timer.sv
module tfb_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_frame_builder.sv
module tx_frame_builder
  import tfb_pkg::*;
#(
  parameter int BUF_BYTES   = 1536,
  parameter int LEN_W       = 12,
  parameter int TIMEOUT_CYC = 100000,
  localparam int ADDR_W     = $clog2(BUF_BYTES),
  localparam int PTR_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [47:0]       dst_addr,
  input  logic [47:0]       src_addr,
  input  logic [15:0]       eth_type,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              pay_valid,
  input  logic [7:0]        pay_data,
  output logic              pay_ready,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              desc_wr,
  output logic [31:0]       desc_status,
  input  logic              tx_own,
  input  logic              tx_ok,
  output logic              tx_run,
  output logic              busy,
  output logic              done,
  output logic [2:0]        res_code
);

  st_e              st;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      ptr16;
  logic [47:0]      dst_q, src_q;
  logic [15:0]      typ_q;
  logic [11:0]      end_q, flen_q;
  logic             nopay_q;
  res_e             res_q;
  logic             done_q, run_q;

  // Named events used by the checker and the FSM.
  logic [11:0] calc_end, calc_flen;
  logic        calc_big;
  logic        accept_go, reject_go, wait_tmo, fin_go;
  kind_e       kind;

  tfb_lencalc #(.BUF_BYTES(BUF_BYTES)) u_len (
    .plen      (16'(pay_len)),
    .end_len   (calc_end),
    .frame_len (calc_flen),
    .too_big   (calc_big)
  );

  tfb_timer #(.CYCLES(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st == S_WAIT),
    .expired (wait_tmo)
  );

  always_comb begin
    unique case (st)
      S_HDR:   kind = K_HDR;
      S_PAY:   kind = K_PAY;
      default: kind = K_PAD;
    endcase
  end

  tfb_bytesel u_sel (
    .kind    (kind),
    .hdr_idx (ptr[3:0]),
    .dst     (dst_q),
    .src     (src_q),
    .typ     (typ_q),
    .pay     (pay_data),
    .wdata   (buf_wdata)
  );

  assign ptr16     = 16'(ptr);
  assign accept_go = (st == S_IDLE) && start && !calc_big;
  assign reject_go = (st == S_IDLE) && start && calc_big;
  assign fin_go    = (st == S_WAIT) && (!tx_own || wait_tmo);

  assign pay_ready   = (st == S_PAY);
  assign buf_we      = (st == S_HDR) || (st == S_PAD) || ((st == S_PAY) && pay_valid);
  assign buf_addr    = ptr[ADDR_W-1:0];
  assign desc_wr     = (st == S_POST);
  assign desc_status = desc_wr ? status_word(flen_q) : 32'd0;
  assign tx_run      = run_q;
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign res_code    = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      typ_q   <= '0;
      end_q   <= '0;
      flen_q  <= '0;
      nopay_q <= 1'b0;
      res_q   <= RES_NONE;
      done_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (reject_go) begin
            res_q  <= RES_REJECT;
            done_q <= 1'b1;
          end else if (accept_go) begin
            dst_q   <= dst_addr;
            src_q   <= src_addr;
            typ_q   <= eth_type;
            end_q   <= calc_end;
            flen_q  <= calc_flen;
            nopay_q <= (pay_len == '0);
            res_q   <= RES_NONE;
            run_q   <= 1'b0;
            ptr     <= '0;
            st      <= S_STOP;
          end
        end
        S_STOP: st <= S_HDR;
        S_HDR: begin
          ptr <= ptr + 1'b1;
          if (ptr16 == 16'(HDR_BYTES - 1)) st <= nopay_q ? S_PAD : S_PAY;
        end
        S_PAY: begin
          if (pay_valid) begin
            ptr <= ptr + 1'b1;
            if (ptr16 + 16'd1 == 16'(end_q))
              st <= (end_q < flen_q) ? S_PAD : S_POST;
          end
        end
        S_PAD: begin
          ptr <= ptr + 1'b1;
          if (ptr16 + 16'd1 == 16'(flen_q)) st <= S_POST;
        end
        S_POST: begin
          run_q <= 1'b1;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (fin_go) begin
            if (!tx_own) res_q <= tx_ok ? RES_OK : RES_TXERR;
            else         res_q <= RES_TIMEOUT;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tfb_chk.sv
module tfb_chk #(
  parameter int BUF_BYTES = 1536,
  parameter int ADDR_W    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              desc_wr,
  input logic [31:0]       desc_status,
  input logic              tx_run,
  input logic              done,
  input logic [2:0]        res_code
);

  // R4: posted word owns the descriptor and carries a legal length.
  a_r4_desc_owned: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |-> (desc_status[31] && desc_status[30:12] == 19'd0 && desc_status[11:0] >= 12'd60));

  // R5: transmitter is held off while the buffer is being written.
  a_r5_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !tx_run);

  // R5: transmitter runs right after the descriptor is posted.
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |=> tx_run);

  // R8: no write lands outside the buffer.
  a_r8_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (32'(buf_addr) < BUF_BYTES));

  // R9: the result only moves with a done pulse or a clear to NONE.
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_code) |-> (done || res_code == 3'd0));

  // R4: descriptor strobe lasts a single cycle.
  a_r4_single_post: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |=> !desc_wr);

endmodule

bind tx_frame_builder tfb_chk #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .buf_we      (buf_we),
  .buf_addr    (buf_addr),
  .desc_wr     (desc_wr),
  .desc_status (desc_status),
  .tx_run      (tx_run),
  .done        (done),
  .res_code    (res_code)
);

// File: tb/tx_frame_builder_tb.sv
module tx_frame_builder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUF  = 128;
  localparam int LW   = 12;
  localparam int TMO  = 40;
  localparam int AW   = $clog2(BUF);

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [47:0] dst_addr = '0, src_addr = '0;
  logic [15:0] eth_type = '0;
  logic [LW-1:0] pay_len = '0;
  logic pay_valid = 0;
  logic [7:0] pay_data = '0;
  logic pay_ready, buf_we, desc_wr, tx_run, busy, done;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [31:0] desc_status;
  logic tx_own = 1, tx_ok = 0;
  logic [2:0] res_code;

  int n_tests = 0, n_fail = 0, desc_seen = 0;
  logic [25:0] exp_q[$];  // {tag(2), addr(16), data(8)}

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_builder #(.BUF_BYTES(BUF), .LEN_W(LW), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr), .src_addr(src_addr),
    .eth_type(eth_type), .pay_len(pay_len), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_ready(pay_ready), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .desc_wr(desc_wr), .desc_status(desc_status), .tx_own(tx_own), .tx_ok(tx_ok),
    .tx_run(tx_run), .busy(busy), .done(done), .res_code(res_code));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every buffer write.
  always @(negedge clk) begin
    if (rst_n && desc_wr) desc_seen++;
    if (rst_n && buf_we) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected buffer write", {24'd0, buf_wdata}, 32'hFFFF);
      end else begin
        logic [25:0] it;
        string tg;
        it = exp_q.pop_front();
        tg = (it[25:24] == 2'd1) ? "R1" : (it[25:24] == 2'd2) ? "R2" : "R3";
        check(tg, "write address", 32'(buf_addr), 32'(it[23:8]));
        check(tg, "write data", 32'(buf_wdata), 32'(it[7:0]));
      end
    end
  end

  function automatic logic [7:0] pbyte(input int i, input int len);
    return 8'(i * 7 + len + 3);
  endfunction

  task automatic pulse_start(input logic [47:0] d, input logic [47:0] s, input logic [15:0] t, input int len);
    @(posedge clk); #1;
    start = 1; dst_addr = d; src_addr = s; eth_type = t; pay_len = LW'(len);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic run_frame(input logic [47:0] d, input logic [47:0] s, input logic [15:0] t,
                           input int len, input int gap, input int delay, input bit okbit,
                           input bit poke, input logic [2:0] exp_res, input string rtag);
    int raw, flen, idx, cyc, n;
    bit acc;
    raw  = len + 14;
    flen = (raw % 4096 < 60) ? 60 : raw % 4096;
    for (int i = 0; i < 14; i++) begin
      logic [111:0] h;
      h = {d, s, t};
      exp_q.push_back({2'd1, 16'(i), h[111 - 8*i -: 8]});
    end
    for (int i = 0; i < len; i++) exp_q.push_back({2'd2, 16'(14 + i), pbyte(i, len)});
    for (int i = raw; i < 60; i++) exp_q.push_back({2'd3, 16'(i), 8'h00});
    pulse_start(d, s, t, len);
    @(negedge clk);
    check("R5", "tx_run after accept", 32'(tx_run), 0);
    check("R9", "result cleared on accept", 32'(res_code), 0);
    // payload feed
    idx = 0; cyc = 0;
    while (idx < len) begin
      pay_valid = (gap == 0) || ((cyc % gap) != 1);
      pay_data  = pbyte(idx, len);
      if (poke && cyc == 3) begin
        start = 1; dst_addr = 48'hFFFF_FFFF_FFFF; pay_len = LW'(4000);
      end else start = 0;
      @(negedge clk);
      acc = pay_valid && pay_ready;
      @(posedge clk); #1;
      if (acc) idx++;
      cyc++;
      if (cyc > 2000) break;
    end
    start = 0; pay_valid = 0;
    // wait for descriptor
    n = 0;
    while (!desc_wr && n < 500) begin @(negedge clk); n++; end
    check("R4", "descriptor status", desc_status, 32'h8000_0000 | 32'(flen));
    check("R5", "tx_run at post", 32'(tx_run), 0);
    check("R3", "all bytes written before post", 32'(exp_q.size()), 0);
    @(posedge clk); #1;
    tx_own = 1;
    @(negedge clk);
    check("R5", "tx_run after post", 32'(tx_run), 1);
    n = 1;
    while (!done && n < 5000) begin
      if (n == delay) begin
        @(posedge clk); #1;
        tx_own = 0; tx_ok = okbit;
      end
      @(negedge clk);
      n++;
    end
    check(rtag, "result code", 32'(res_code), 32'(exp_res));
    if (exp_res == 3'd3) check("R7", "cycles from post to done", 32'(n), 32'(TMO + 1));
    @(posedge clk); #1;
    tx_own = 1; tx_ok = 0;
    @(negedge clk);
    check("R6", "done is one pulse", 32'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ds;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset busy", 32'(busy), 0);
    check("R9", "reset tx_run", 32'(tx_run), 0);
    check("R9", "reset res_code", 32'(res_code), 0);
    check("R9", "reset done", 32'(done), 0);
    rst_n = 1;

    run_frame(48'h0102_0304_0506, 48'hA1A2_A3A4_A5A6, 16'h0800, 5, 0, 3, 1, 0, 3'd1, "R6");
    run_frame(48'h1122_3344_5566, 48'h7788_99AA_BBCC, 16'h86DD, 46, 3, 5, 0, 0, 3'd2, "R6");
    run_frame(48'hDEAD_BEEF_0001, 48'h0000_0000_0002, 16'h0806, 0, 0, 2, 1, 0, 3'd1, "R3");
    run_frame(48'hCAFE_0000_1234, 48'h0A0B_0C0D_0E0F, 16'h1234, 45, 4, 2, 1, 0, 3'd1, "R3");
    run_frame(48'h5555_AAAA_5555, 48'h0F0F_F0F0_0F0F, 16'hABCD, 114, 3, 2, 1, 0, 3'd1, "R8");

    // R8: one byte past the buffer is rejected.
    ds = desc_seen;
    pulse_start(48'h1, 48'h2, 16'h3, 115);
    @(negedge clk);
    check("R8", "reject done pulse", 32'(done), 1);
    check("R8", "reject result", 32'(res_code), 4);
    check("R8", "reject not busy", 32'(busy), 0);
    repeat (6) @(negedge clk);
    check("R8", "no descriptor on reject", 32'(desc_seen), 32'(ds));
    check("R9", "reject result held", 32'(res_code), 4);

    run_frame(48'h0203_0405_0607, 48'h1112_1314_1516, 16'h0042, 20, 0, 1000, 1, 0, 3'd3, "R7");
    // R10: start during a frame is ignored.
    run_frame(48'h3132_3334_3536, 48'h4142_4344_4546, 16'h2020, 30, 0, 4, 1, 1, 3'd1, "R10");
    repeat (8) @(negedge clk);
    check("R9", "OK result held while idle", 32'(res_code), 1);
    check("R10", "no stray writes", 32'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule